// File: doc/BRIEF.md
# Lean Graph Edge Trimming Engine

This block prunes a bipartite graph held as a bitmap with one live bit per edge. Every edge joins one node on side 0 to one node on side 1. The node an edge reaches on a given side comes from a keyed mixing function of the edge index and the side. Trimming goes in rounds. A round deals with one side of the graph, and the two sides take turns, starting with side 0. The block only has room for degree counters covering a slice of one side's nodes. Each round is therefore split into 2^k passes, and each pass handles one slice.

A pass has three phases. It first clears the slice's counters. It then sweeps every edge and counts how many live edges touch each node of the slice. Last, it sweeps the edges again and kills each live edge whose node in the slice was seen fewer than two times. An edge with a dead bit takes no part in counting or testing. The work is serial, one step per clock.

The controlling logic pulses `start` with a key and a round count. It waits for `done`, then fetches the surviving bitmap one bit at a time through a valid/ready request/response port. A request is only taken while the engine is idle. A response that the consumer does not accept holds its value and blocks further requests. Signals `start`, `busy` and `done` are plain control pins.

Top module: `lgt_trim_engine`

## Requirements
- R1: After reset, `busy`, `done` and `rd_rsp_valid` are 0 and `rd_req_ready` is 1.
- R2: A `start` seen while idle sets every live bit to 1, samples `round_count` and `hash_key`, and begins the run. A `start` seen while `busy` is 1 has no effect on the timing or the result of the run in progress.
- R3: The node an edge reaches is computed on 32-bit unsigned values with wrap-around. The steps are: x = key ^ (idx * 0x9E3779B1) ^ (side ? 0x85EBCA6B : 0); x ^= x >> 15; x *= 0x2C1B3C6D; x ^= x >> 12. The node is the low NODE_W bits of x.
- R4: Round r trims side r mod 2. It runs 2^SLICE_SHIFT passes, and pass p handles the nodes whose top SLICE_SHIFT bits equal p.
- R5: At the start of each pass, every counter of the slice reads 0. In the counting sweep, each live edge whose node lies in the slice adds 1 to that node's counter, which saturates at 2.
- R6: In the testing sweep, a live edge whose node lies in the slice and whose counter is below 2 is cleared. Edges whose node lies outside the slice, and edges already dead, are left as they are.
- R7: For R > 0 rounds, `busy` is 1 for exactly R * 2^SLICE_SHIFT * (2^(NODE_W-SLICE_SHIFT) + 2^(NODE_W+1)) cycles, beginning with the edge that takes `start`. `done` then rises and stays at 1 until the next accepted `start`.
- R8: A `start` with `round_count` = 0 sets `done` at the same edge and leaves every live bit at 1.
- R9: A read request (`rd_req_valid`, address `rd_req_addr`) is taken at an edge where `rd_req_ready` is 1. Its live bit appears on `rd_rsp_live` with `rd_rsp_valid` after that edge. The response holds, unchanged, until an edge with `rd_rsp_ready` = 1. `rd_req_ready` is 0 while `busy` is 1, and also while a response is held back.
- R10: When `done` is 1, the bitmap read back equals the result of R rounds of leaf trimming as described in R3 to R6, with bit i standing for edge i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken only when idle) |
| round_count | input | ROUND_W | Number of rounds for the run |
| hash_key | input | 32 | Key for the node mixing function |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run complete, bitmap valid |
| rd_req_valid | input | 1 | Read request present |
| rd_req_ready | output | 1 | Read request can be taken |
| rd_req_addr | input | NODE_W | Edge index to read |
| rd_rsp_valid | output | 1 | Read response present |
| rd_rsp_ready | input | 1 | Consumer takes the response |
| rd_rsp_live | output | 1 | Live bit of the requested edge |

## Verification
The bench keeps the defaults, which give 256 edges and two slices per side. Every round therefore goes through both the in-slice and the out-of-slice paths, and a multi-round run reaches a stable core in a few thousand cycles. Odd and even round counts end on different sides. Zero rounds covers the idle-to-done shortcut. Holding back responses during a full readback exercises the stall path on the read port.

// File: rtl/lgt_pkg.sv
package lgt_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CLEAR = 2'd1,
    PH_COUNT = 2'd2,
    PH_KILL  = 2'd3
  } phase_e;

  // Placeholder keyed mixer of (edge index, side); full 32-bit result.
  function automatic logic [31:0] node_mix(input logic [31:0] key,
                                           input logic [31:0] idx,
                                           input logic        side);
    logic [31:0] x;
    x = key ^ (idx * 32'h9E37_79B1) ^ (side ? 32'h85EB_CA6B : 32'h0);
    x = x ^ (x >> 15);
    x = x * 32'h2C1B_3C6D;
    x = x ^ (x >> 12);
    return x;
  endfunction

endpackage

// File: rtl/lgt_node_hash.sv
module lgt_node_hash #(
  parameter int NODE_W = 8
) (
  input  logic [31:0]       key,
  input  logic [NODE_W-1:0] idx,
  input  logic              side,
  output logic [NODE_W-1:0] node
);
  assign node = NODE_W'(lgt_pkg::node_mix(key, 32'(idx), side));
endmodule

// File: rtl/lgt_degree_store.sv
module lgt_degree_store #(
  parameter int LOC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_en,
  input  logic             inc_en,
  input  logic [LOC_W-1:0] addr,
  output logic [1:0]       rd_cnt
);
  localparam int DEPTH = 1 << LOC_W;

  logic [1:0] cnt_q [DEPTH];

  assign rd_cnt = cnt_q[addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cnt_q[i] <= 2'd0;
    end else if (clr_en) begin
      cnt_q[addr] <= 2'd0;
    end else if (inc_en && cnt_q[addr] != 2'd2) begin
      cnt_q[addr] <= cnt_q[addr] + 2'd1;
    end
  end

  // R5: counters saturate at two, code 3 never appears
  p_cnt_saturates_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt != 2'd3);

  // R5: a cleared counter reads zero on the following cycle
  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !inc_en) |=> (cnt_q[$past(addr)] == 2'd0));

endmodule

// File: rtl/lgt_sweep_ctrl.sv
module lgt_sweep_ctrl
  import lgt_pkg::*;
#(
  parameter int NODE_W      = 8,
  parameter int SLICE_SHIFT = 1,
  parameter int ROUND_W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ROUND_W-1:0] round_count,
  output phase_e             phase,
  output logic [NODE_W-1:0]  idx,
  output logic [(SLICE_SHIFT>0 ? SLICE_SHIFT : 1)-1:0] pass,
  output logic               side,
  output logic               launch,
  output logic               done
);
  localparam int PASS_W      = (SLICE_SHIFT > 0) ? SLICE_SHIFT : 1;
  localparam int PASSES      = 1 << SLICE_SHIFT;
  localparam int SLICE_NODES = 1 << (NODE_W - SLICE_SHIFT);
  localparam int EDGES       = 1 << NODE_W;
  localparam logic [NODE_W-1:0] CLR_LAST  = NODE_W'(SLICE_NODES - 1);
  localparam logic [NODE_W-1:0] EDGE_LAST = NODE_W'(EDGES - 1);
  localparam logic [PASS_W-1:0] PASS_LAST = PASS_W'(PASSES - 1);

  logic [ROUND_W-1:0] round_q, round_lim;

  assign launch = start && (phase == PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      idx       <= '0;
      pass      <= '0;
      side      <= 1'b0;
      round_q   <= '0;
      round_lim <= '0;
      done      <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            round_lim <= round_count;
            round_q   <= '0;
            idx       <= '0;
            pass      <= '0;
            side      <= 1'b0;
            done      <= (round_count == '0);
            phase     <= (round_count == '0) ? PH_IDLE : PH_CLEAR;
          end
        end
        PH_CLEAR: begin
          if (idx == CLR_LAST) begin
            idx   <= '0;
            phase <= PH_COUNT;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        PH_COUNT: begin
          if (idx == EDGE_LAST) begin
            idx   <= '0;
            phase <= PH_KILL;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        PH_KILL: begin
          if (idx == EDGE_LAST) begin
            idx <= '0;
            if (pass == PASS_LAST) begin
              pass <= '0;
              side <= ~side;
              if (round_q == round_lim - 1'b1) begin
                phase <= PH_IDLE;
                done  <= 1'b1;
              end else begin
                round_q <= round_q + 1'b1;
                phase   <= PH_CLEAR;
              end
            end else begin
              pass  <= pass + 1'b1;
              phase <= PH_CLEAR;
            end
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R7: done only while idle
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (phase == PH_IDLE));

  // R2: a start during a run leaves the sampled round limit alone
  p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |=> $stable(round_lim));

  // R4: side flips only on leaving a testing sweep
  p_side_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_KILL && !launch) |=> $stable(side));

  // R5: every pass starts with a clearing phase
  p_count_after_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_COUNT && idx == '0) |-> $past(phase) == PH_CLEAR);

endmodule

// File: rtl/lgt_readout.sv
module lgt_readout #(
  parameter int NODE_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   allow,
  input  logic [(1<<NODE_W)-1:0] live,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [NODE_W-1:0]      req_addr,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic                   rsp_bit
);
  assign req_ready = allow && (!rsp_valid || rsp_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_bit   <= 1'b0;
    end else if (req_valid && req_ready) begin
      rsp_valid <= 1'b1;
      rsp_bit   <= live[req_addr];
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R9: a stalled response stays put
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_bit)));

endmodule

// File: rtl/lgt_trim_engine.sv
module lgt_trim_engine
  import lgt_pkg::*;
#(
  parameter int NODE_W      = 8,
  parameter int SLICE_SHIFT = 1,
  parameter int ROUND_W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ROUND_W-1:0] round_count,
  input  logic [31:0]        hash_key,
  output logic               busy,
  output logic               done,
  input  logic               rd_req_valid,
  output logic               rd_req_ready,
  input  logic [NODE_W-1:0]  rd_req_addr,
  output logic               rd_rsp_valid,
  input  logic               rd_rsp_ready,
  output logic               rd_rsp_live
);
  localparam int EDGES  = 1 << NODE_W;
  localparam int LOC_W  = NODE_W - SLICE_SHIFT;
  localparam int PASS_W = (SLICE_SHIFT > 0) ? SLICE_SHIFT : 1;

  phase_e              phase;
  logic [NODE_W-1:0]   idx, node;
  logic [PASS_W-1:0]   pass;
  logic                side, launch, in_slice, kill;
  logic [31:0]         key_q;
  logic [EDGES-1:0]    live;
  logic [LOC_W-1:0]    deg_addr;
  logic [1:0]          deg_cnt;

  lgt_sweep_ctrl #(.NODE_W(NODE_W), .SLICE_SHIFT(SLICE_SHIFT), .ROUND_W(ROUND_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .round_count(round_count),
    .phase(phase), .idx(idx), .pass(pass), .side(side),
    .launch(launch), .done(done)
  );

  lgt_node_hash #(.NODE_W(NODE_W)) hash_i (
    .key(key_q), .idx(idx), .side(side), .node(node)
  );

  generate
    if (SLICE_SHIFT == 0) begin : g_one_slice
      assign in_slice = 1'b1;
    end else begin : g_sliced
      assign in_slice = (node[NODE_W-1 -: SLICE_SHIFT] == pass);
    end
  endgenerate

  assign deg_addr = (phase == PH_CLEAR) ? idx[LOC_W-1:0] : node[LOC_W-1:0];

  lgt_degree_store #(.LOC_W(LOC_W)) deg_i (
    .clk(clk), .rst_n(rst_n),
    .clr_en(phase == PH_CLEAR),
    .inc_en(phase == PH_COUNT && live[idx] && in_slice),
    .addr(deg_addr), .rd_cnt(deg_cnt)
  );

  assign kill = (phase == PH_KILL) && live[idx] && in_slice && (deg_cnt < 2'd2);
  assign busy = (phase != PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live  <= '0;
      key_q <= '0;
    end else if (launch) begin
      live  <= '1;
      key_q <= hash_key;
    end else if (kill) begin
      live[idx] <= 1'b0;
    end
  end

  lgt_readout #(.NODE_W(NODE_W)) rd_i (
    .clk(clk), .rst_n(rst_n), .allow(!busy), .live(live),
    .req_valid(rd_req_valid), .req_ready(rd_req_ready), .req_addr(rd_req_addr),
    .rsp_valid(rd_rsp_valid), .rsp_ready(rd_rsp_ready), .rsp_bit(rd_rsp_live)
  );

  // R6: without a new start, live edges only ever disappear
  p_no_revive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> ($countones(live) <= $countones($past(live))));

  // R6: at most one edge dies per cycle
  p_one_kill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !launch) |=> ($countones($past(live)) - $countones(live) <= 1));

  // R9: no reads while a run is in progress
  p_no_read_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rd_req_ready);

  // R8: zero rounds keeps the full bitmap
  p_zero_round_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && round_count == '0) |=> (live == '1 && done));

endmodule

// File: tb/lgt_trim_engine_tb_top.sv
module lgt_trim_engine_tb_top;
  localparam int NODE_W = 8;
  localparam int K      = 1;
  localparam int E      = 1 << NODE_W;
  localparam int P      = 1 << K;
  localparam int S      = 1 << (NODE_W - K);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0]  round_count = '0;
  logic [31:0] hash_key = '0;
  logic busy, done, rd_req_ready, rd_rsp_valid, rd_rsp_live;
  logic rd_req_valid = 1'b0, rd_rsp_ready = 1'b1;
  logic [NODE_W-1:0] rd_req_addr = '0;

  int checks = 0, errors = 0;
  int m_rem = 0;
  bit m_done = 0;
  bit exp_live [E];

  always #10 clk = ~clk;

  lgt_trim_engine #(.NODE_W(NODE_W), .SLICE_SHIFT(K), .ROUND_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .round_count(round_count),
    .hash_key(hash_key), .busy(busy), .done(done),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_live(rd_rsp_live)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int unsigned node_of(int unsigned key, int unsigned e, bit sd);
    int unsigned x;
    x = key ^ (e * 32'h9E37_79B1) ^ (sd ? 32'h85EB_CA6B : 32'h0);
    x = x ^ (x >> 15);
    x = x * 32'h2C1B_3C6D;
    x = x ^ (x >> 12);
    return x % E;
  endfunction

  // Behavioural reference of R3..R6 and R10
  task automatic reference(input int unsigned key, input int rounds);
    int cnt [S];
    for (int e = 0; e < E; e++) exp_live[e] = 1;
    for (int r = 0; r < rounds; r++) begin
      for (int p = 0; p < P; p++) begin
        for (int j = 0; j < S; j++) cnt[j] = 0;
        for (int e = 0; e < E; e++) begin
          int unsigned n = node_of(key, e, r % 2);
          if (exp_live[e] && (n / S) == p && cnt[n % S] < 2) cnt[n % S]++;
        end
        for (int e = 0; e < E; e++) begin
          int unsigned n = node_of(key, e, r % 2);
          if (exp_live[e] && (n / S) == p && cnt[n % S] < 2) exp_live[e] = 0;
        end
      end
    end
  endtask

  // Cycle model of busy/done (R2, R7, R8)
  always @(posedge clk) begin
    if (!rst_n) begin
      m_rem = 0; m_done = 0;
    end else if (start && m_rem == 0) begin
      m_rem  = int'(round_count) * P * (S + 2 * E);
      m_done = (m_rem == 0);
      reference(hash_key, int'(round_count));
    end else if (m_rem > 0) begin
      m_rem--;
      if (m_rem == 0) m_done = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == (m_rem > 0), "R7 busy", busy, m_rem > 0);
      chk(done == m_done, "R7 done", done, m_done);
    end
  end

  task automatic run(input int unsigned key, input int rounds, input bit poke);
    @(negedge clk);
    hash_key = key; round_count = 8'(rounds); start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (50) @(negedge clk);
      chk(rd_req_ready == 0, "R9 ready low while busy", rd_req_ready, 0);
      round_count = 8'd2; hash_key = 32'h5555_AAAA; start = 1;  // R2: ignored
      @(negedge clk);
      start = 0;
    end
    while (!done) @(negedge clk);
  endtask

  task automatic readback(input string req, input bit stall);
    int live_cnt = 0, exp_cnt = 0;
    for (int e = 0; e < E; e++) begin
      @(negedge clk);
      rd_req_valid = 1; rd_req_addr = NODE_W'(e); rd_rsp_ready = !stall;
      chk(rd_req_ready == 1, "R9 ready idle", rd_req_ready, 1);
      @(negedge clk);
      rd_req_valid = 0;
      chk(rd_rsp_valid == 1, "R9 rsp valid", rd_rsp_valid, 1);
      chk(rd_rsp_live == exp_live[e], req, rd_rsp_live, exp_live[e]);
      if (stall) begin
        logic held = rd_rsp_live;
        repeat (2) begin
          @(negedge clk);
          chk(rd_rsp_valid && rd_rsp_live == held, "R9 hold", rd_rsp_live, held);
          chk(rd_req_ready == 0, "R9 stall blocks", rd_req_ready, 0);
        end
        rd_rsp_ready = 1;
        @(negedge clk);
      end
      live_cnt += rd_rsp_live;
      exp_cnt  += exp_live[e];
    end
    rd_rsp_ready = 1;
    chk(live_cnt == exp_cnt, {req, " survivors"}, live_cnt, exp_cnt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1 busy", busy, 0);
    chk(done == 0, "R1 done", done, 0);
    chk(rd_rsp_valid == 0, "R1 rsp_valid", rd_rsp_valid, 0);
    chk(rd_req_ready == 1, "R1 req_ready", rd_req_ready, 1);
    rst_n = 1;
    // R3 R4 R5 R6: single round, side 0 only
    run(32'h1234_5678, 1, 0);
    readback("R10 one round", 0);
    // R2 R10: six rounds with a start poked mid-run
    run(32'hDEAD_BEEF, 6, 1);
    readback("R10 six rounds", 0);
    // R8: zero rounds
    run(32'h0BAD_F00D, 0, 0);
    chk(done == 1, "R8 done", done, 1);
    readback("R8 all live", 0);
    // R4 R9: odd count ends on side 0, readback with stalls
    run(32'h0F0F_3C3C, 3, 0);
    readback("R10 three rounds", 1);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule